// File: doc/BRIEF.md
# Constant Off-Time PWM Current Chopper

This block regulates the load current of motor bridges by chopping at a fixed off time. Each bridge has a sense comparator whose digital result goes high when the measured current is above the reference. When the block accepts such a trip, it raises a chop request. The bridge sequencer answers that request by releasing the low-side switch, so the current recirculates. The request stays high for a programmed number of clock cycles and then drops, and the bridge conducts again. The off time is constant. The period is not: it follows from how fast the current rises again.

Two guards keep the reverse-recovery current spike that follows every turn-on from retriggering the chopper. A blanking window discards comparator activity at the start of each on phase. An enforced minimum on time holds back any accepted trip until the on phase has lasted long enough. The block does not generate the gate deadtime. It adds the deadtime that the sequencer inserts to the programmed off time, and reports that sum as the effective off period of the interval in progress.

One independent controller is built per bridge. All timing is given in clock cycles, so a 50 MHz clock with the default parameters gives a 1 µs blanking window and a 1.5 µs minimum on time. That is enough for chopping rates up to 100 kHz.

Top module: `cot_chopper`

## Requirements
- R1: When the comparator input of a channel is high in an on-phase cycle that is at index k ≥ max(BLANK_CYC, MINON_CYC−1) of that phase, the chop request of that channel is high from the next cycle. Index 0 is the first cycle of the phase.
- R2: The chop request then stays high for exactly T cycles and falls on its own. T is the off reload latched at the trip, and a reload of 0 acts as 1. The comparator input has no effect while the request is high.
- R3: A comparator trip seen at an index in [BLANK_CYC, MINON_CYC−2] is held. It starts the off interval at index MINON_CYC−1, so the request is never high before MINON_CYC on cycles have passed.
- R4: Comparator activity in the first BLANK_CYC cycles (indices 0 to BLANK_CYC−1) of each on phase is discarded and not remembered.
- R5: The effective-off output of a channel shows T + DEAD_CYC from the cycle in which the request rises, and it holds that value for the whole interval.
- R6: When a channel's enable is low at a clock edge, its request is low from the next cycle. The cycle in which the enable is seen high again is index 0 of a new on phase, with blanking active again.
- R7: A change of a channel's off reload while its request is high does not change the length of that interval. The next trip uses the new value.
- R8: Each channel acts only on its own comparator, enable and reload, and channels chop concurrently without affecting each other.
- R9: Synchronous active-high reset clears every request and effective-off output to 0. The cycle in which reset is first seen low is index 0 of an on phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bridge_en | input | NB | Per-channel enable qualifier |
| over_ref | input | NB | Per-channel comparator result, high when current exceeds reference |
| toff_cfg | input | NB*TW | Per-channel off-time reload in cycles, channel c at bits [c*TW +: TW] |
| chop_req | output | NB | Registered per-channel off-phase request |
| eff_off | output | NB*EW | Registered per-channel effective off period (reload + deadtime), channel c at [c*EW +: EW] |

## Verification
A comparator input driven in cycle n is sampled at the following edge. An accepted trip therefore shows on chop_req and eff_off one cycle later, and the request falls exactly T cycles after it rose. A change of the enable shows one cycle after the edge that samples it. For each scenario the driver works out these edge cycles from the on-phase start index and queues them with the expected effective-off value. A monitor samples on the falling clock edge, pops the queue on every edge of chop_req and compares the cycle number and the value. Any edge that was not queued is a failure, so a trip that should have been discarded or ignored is caught by its absence. Blanking boundaries, held trips, a reload of zero, a reload change in mid-interval and disable during the off phase are each given their own exact due cycle.

// File: rtl/cot_chop_pkg.sv
package cot_chop_pkg;

  typedef enum logic {
    PH_ON  = 1'b0,
    PH_OFF = 1'b1
  } chop_phase_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cot_on_window.sv
// Counts the on phase, masks the comparator during blanking and holds a
// trip seen after blanking until the minimum on time has passed.
module cot_on_window #(
  parameter int unsigned BLANK_CYC = 50,
  parameter int unsigned MINON_CYC = 75
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,      // off phase or disabled: restart the on phase
  input  logic over_ref,
  output logic trip_go
);
  import cot_chop_pkg::*;

  localparam int unsigned LIM = max_u(max_u(BLANK_CYC, MINON_CYC), 1);
  localparam int unsigned CW  = $clog2(LIM + 1);
  localparam logic [CW-1:0] LIM_L   = CW'(LIM);
  localparam logic [CW-1:0] BLANK_L = CW'(BLANK_CYC);
  localparam logic [CW-1:0] MIN_L   = CW'((MINON_CYC > 0) ? MINON_CYC - 1 : 0);

  logic [CW-1:0] on_cnt;
  logic          pending;
  logic          open_w;
  logic          min_ok;

  assign open_w  = (on_cnt >= BLANK_L);
  assign min_ok  = (on_cnt >= MIN_L);
  assign trip_go = !hold && open_w && min_ok && (over_ref || pending);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      on_cnt  <= '0;
      pending <= 1'b0;
    end else begin
      if (on_cnt != LIM_L) on_cnt <= on_cnt + 1'b1;
      if (trip_go)                pending <= 1'b0;
      else if (open_w && over_ref) pending <= 1'b1;
    end
  end

  // R4: no trip may be remembered while the blanking window is still open
  a_r4_blank_not_queued: assert property (@(posedge clk) disable iff (rst)
    (!hold && on_cnt < BLANK_L) |-> !pending);

endmodule

// File: rtl/cot_off_timer.sv
// Down counter for the off interval; reload is guaranteed non-zero upstream.
module cot_off_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          start,
  input  logic [TW-1:0] reload,
  output logic          busy,
  output logic          expire
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] cnt;

  assign expire = busy && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= reload;
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == ONE) begin
        cnt  <= '0;
        busy <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R2: a running interval always has cycles left to count
  a_r2_count_live: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt != '0));

endmodule

// File: rtl/cot_chop_channel.sv
// One independent chopper for one bridge.
module cot_chop_channel #(
  parameter int unsigned TW        = 16,
  parameter int unsigned EW        = 17,
  parameter int unsigned BLANK_CYC = 50,
  parameter int unsigned MINON_CYC = 75,
  parameter int unsigned DEAD_CYC  = 50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          over_ref,
  input  logic [TW-1:0] toff,
  output logic          chop_req,
  output logic [EW-1:0] eff_off
);
  import cot_chop_pkg::*;

  chop_phase_e   phase_q;
  logic [EW-1:0] eff_q;
  logic          trip_go;
  logic          tmr_busy;
  logic          tmr_expire;
  logic          hold;
  logic [TW-1:0] toff_use;

  assign hold     = !en || (phase_q == PH_OFF);
  assign toff_use = (toff == '0) ? TW'(1) : toff;

  cot_on_window #(
    .BLANK_CYC(BLANK_CYC),
    .MINON_CYC(MINON_CYC)
  ) win_i (
    .clk     (clk),
    .rst     (rst),
    .hold    (hold),
    .over_ref(over_ref),
    .trip_go (trip_go)
  );

  cot_off_timer #(.TW(TW)) tmr_i (
    .clk   (clk),
    .rst   (rst),
    .abort (!en),
    .start (trip_go),
    .reload(toff_use),
    .busy  (tmr_busy),
    .expire(tmr_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_ON;
      eff_q   <= '0;
    end else if (!en) begin
      phase_q <= PH_ON;
    end else if (phase_q == PH_ON && trip_go) begin
      phase_q <= PH_OFF;
      eff_q   <= EW'(toff_use) + EW'(DEAD_CYC);
    end else if (phase_q == PH_OFF && tmr_expire) begin
      phase_q <= PH_ON;
    end
  end

  assign chop_req = (phase_q == PH_OFF);
  assign eff_off  = eff_q;

  // Independent on-length tally for the minimum on time check.
  localparam int unsigned CK_MAX = max_u(MINON_CYC, 1);
  localparam int unsigned CKW    = $clog2(CK_MAX + 1);
  logic [CKW-1:0] ck_len;
  always_ff @(posedge clk) begin
    if (rst || !en || phase_q == PH_OFF) ck_len <= '0;
    else if (ck_len != CKW'(CK_MAX))     ck_len <= ck_len + 1'b1;
  end

  // R3: an off interval starts only after the minimum on time
  a_r3_min_on: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_ON && trip_go) |-> (ck_len >= CKW'(CK_MAX - 1)));

  // R6: a low enable forces the on phase at the next cycle
  a_r6_disable_drops: assert property (@(posedge clk) disable iff (rst)
    !en |=> (phase_q == PH_ON));

  // R2: the off phase and the interval timer agree
  a_r2_off_timed: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_OFF) |-> tmr_busy);

  // R5: the reported period is frozen during an interval
  a_r5_eff_hold: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_OFF && $past(phase_q == PH_OFF)) |-> $stable(eff_q));

endmodule

// File: rtl/cot_chopper.sv
// Multi-bridge constant off-time chopper: one independent channel per bridge.
module cot_chopper #(
  parameter int unsigned NB        = 2,
  parameter int unsigned TW        = 16,
  parameter int unsigned BLANK_CYC = 50,
  parameter int unsigned MINON_CYC = 75,
  parameter int unsigned DEAD_CYC  = 50,
  parameter int unsigned EW        = $clog2((1 << TW) + DEAD_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NB-1:0]    bridge_en,
  input  logic [NB-1:0]    over_ref,
  input  logic [NB*TW-1:0] toff_cfg,
  output logic [NB-1:0]    chop_req,
  output logic [NB*EW-1:0] eff_off
);

  for (genvar g = 0; g < NB; g++) begin : g_ch
    cot_chop_channel #(
      .TW       (TW),
      .EW       (EW),
      .BLANK_CYC(BLANK_CYC),
      .MINON_CYC(MINON_CYC),
      .DEAD_CYC (DEAD_CYC)
    ) ch_i (
      .clk     (clk),
      .rst     (rst),
      .en      (bridge_en[g]),
      .over_ref(over_ref[g]),
      .toff    (toff_cfg[g*TW +: TW]),
      .chop_req(chop_req[g]),
      .eff_off (eff_off[g*EW +: EW])
    );
  end

endmodule

// File: tb/cot_chopper_tb_top.sv
module cot_chopper_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2, TW = 8, BLANK = 4, MINON = 6, DEAD = 3;
  localparam int EW = $clog2((1 << TW) + DEAD + 1);

  logic             clk = 1'b0;
  logic             rst;
  logic [NB-1:0]    bridge_en;
  logic [NB-1:0]    over_ref;
  logic [NB*TW-1:0] toff_cfg;
  logic [NB-1:0]    chop_req;
  logic [NB*EW-1:0] eff_off;

  cot_chopper #(
    .NB(NB), .TW(TW), .BLANK_CYC(BLANK), .MINON_CYC(MINON), .DEAD_CYC(DEAD)
  ) dut_i (
    .clk(clk), .rst(rst), .bridge_en(bridge_en), .over_ref(over_ref),
    .toff_cfg(toff_cfg), .chop_req(chop_req), .eff_off(eff_off)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    bit    lvl;
    int    eff;
    string tag;
  } ev_t;

  ev_t expq [NB][$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [NB-1:0] prev_chop = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic push_ev(input int ch, input int at, input bit lvl, input int eff,
                         input string tag);
    ev_t e;
    e.at = at; e.lvl = lvl; e.eff = eff; e.tag = tag;
    expq[ch].push_back(e);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic pulse(input int ch, input int c);
    wait_until(c);
    over_ref[ch] = 1'b1;
    @(negedge clk);
    over_ref[ch] = 1'b0;
  endtask

  task automatic set_toff(input int ch, input int v);
    toff_cfg[ch*TW +: TW] = TW'(v);
  endtask

  // Monitor: every edge of a request must match the next queued expectation.
  always @(negedge clk) begin
    for (int ch = 0; ch < NB; ch++) begin
      if (chop_req[ch] !== prev_chop[ch]) begin
        if (expq[ch].size() == 0) begin
          check(1'b0, "R8", $sformatf("unexpected edge on channel %0d", ch), cyc, -1);
        end else begin
          ev_t e;
          e = expq[ch].pop_front();
          check(e.at == cyc && e.lvl == chop_req[ch], e.tag,
                $sformatf("ch%0d edge to %0d at cycle", ch, e.lvl), cyc, e.at);
          if (e.lvl)
            check(int'(eff_off[ch*EW +: EW]) == e.eff, "R5",
                  $sformatf("ch%0d eff_off", ch), int'(eff_off[ch*EW +: EW]), e.eff);
        end
      end
    end
    prev_chop <= chop_req;
  end

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual %0d cycles expected fewer than 5000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int t0, tb, tc, td, te, tf;
    rst = 1'b1; bridge_en = '1; over_ref = '0; toff_cfg = '0;
    repeat (3) @(negedge clk);
    check(chop_req == '0, "R9", "chop_req in reset", int'(chop_req), 0);
    check(eff_off == '0, "R9", "eff_off in reset", int'(eff_off), 0);
    set_toff(0, 10);
    set_toff(1, 5);
    rst = 1'b0;
    t0 = cyc;

    // R1/R2: trip at index 5 with comparator held high through the off phase
    push_ev(0, t0 + 6, 1'b1, 13, "R1");
    push_ev(0, t0 + 16, 1'b0, 0, "R2");
    wait_until(t0 + 5);
    over_ref[0] = 1'b1;
    wait_until(t0 + 16);
    over_ref[0] = 1'b0;

    // R4: a trip in the last blanking cycle is discarded
    tb = t0 + 16;
    pulse(0, tb + 3);
    wait_until(tb + 9);
    check(chop_req[0] == 1'b0, "R4", "chop_req after blanked trip", int'(chop_req[0]), 0);
    // R7: reload changed mid-interval; this interval keeps 10
    push_ev(0, tb + 11, 1'b1, 13, "R1");
    push_ev(0, tb + 21, 1'b0, 0, "R7");
    pulse(0, tb + 10);
    wait_until(tb + 13);
    set_toff(0, 4);

    // R3: trip right after blanking is held until the minimum on time
    tc = tb + 21;
    push_ev(0, tc + 6, 1'b1, 7, "R3");
    push_ev(0, tc + 10, 1'b0, 0, "R7");
    pulse(0, tc + 4);
    wait_until(tc + 5);
    check(chop_req[0] == 1'b0, "R3", "chop_req before minimum on time", int'(chop_req[0]), 0);

    // R2: reload of zero acts as one cycle
    td = tc + 10;
    wait_until(td);
    set_toff(0, 0);
    push_ev(0, td + 8, 1'b1, 4, "R2");
    push_ev(0, td + 9, 1'b0, 0, "R2");
    pulse(0, td + 7);

    // R6: disable during the off phase, then re-enable with blanking armed
    te = td + 9;
    wait_until(te);
    set_toff(0, 20);
    push_ev(0, te + 7, 1'b1, 23, "R6");
    push_ev(0, te + 11, 1'b0, 0, "R6");
    pulse(0, te + 6);
    wait_until(te + 10);
    bridge_en[0] = 1'b0;
    wait_until(te + 12);
    over_ref[0] = 1'b1;
    wait_until(te + 15);
    over_ref[0] = 1'b0;
    wait_until(te + 16);
    bridge_en[0] = 1'b1;
    over_ref[0] = 1'b1;
    wait_until(te + 19);
    over_ref[0] = 1'b0;
    wait_until(te + 26);
    check(chop_req[0] == 1'b0, "R6", "chop_req after re-enable with blanked trip", int'(chop_req[0]), 0);
    check(expq[0].size() == 0, "R6", "pending channel 0 edges", expq[0].size(), 0);

    // R8: both channels chop concurrently with their own reloads
    tf = te + 30;
    push_ev(1, tf + 1, 1'b1, 8, "R8");
    push_ev(1, tf + 6, 1'b0, 0, "R8");
    push_ev(0, tf + 3, 1'b1, 23, "R8");
    push_ev(0, tf + 23, 1'b0, 0, "R8");
    pulse(1, tf);
    pulse(0, tf + 2);
    wait_until(tf + 30);
    check(expq[0].size() == 0, "R8", "pending channel 0 edges", expq[0].size(), 0);
    check(expq[1].size() == 0, "R8", "pending channel 1 edges", expq[1].size(), 0);
    check(chop_req == '0, "R8", "chop_req at end", int'(chop_req), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule